// File: doc/BRIEF.md
# Radix-4 Leading-One Locator

This block finds the most significant set bit of an input word. It produces three results together. A flag says whether any bit is set. A binary index gives the position of the highest set bit. A one-hot mask has only that bit set. Bit WIDTH-1 is the most significant position, so a higher position always wins.

Internally the block is a tree of four-way priority nodes. Each node looks at four child groups, each with its own "any set" flag. It forwards the highest-numbered group whose flag is set, and it picks group 0 when none is set. The node's own flag is the OR of the four child flags. Each level covers four times the span of the level below, until one root node covers the whole word. The node index is built by placing the two-bit code of the chosen child above the index that child reports.

When WIDTH is not a power of four, the word is padded with zeros below bit 0. The padding never appears in the index or the mask. An optional register after the first tree level turns the block into a one-cycle pipeline.

Top module: `lead_one_locator`

## Requirements
- R1: `any_o` is 1 exactly when at least one bit of the input word is 1.
- R2: When `any_o` is 1, `idx_o` is the binary position of the highest set input bit. Bit WIDTH-1 counts as the most significant, and bits below that position have no effect on any output.
- R3: When `any_o` is 1, `mask_o` has exactly one bit set, at position `idx_o`. That bit is also set in the input.
- R4: For an all-zero input, `any_o` is 0, `idx_o` is 0 and `mask_o` is all zeros.
- R5: A WIDTH that is not a power of four gives results in the caller's own bit numbering. The internal padding adds no offset to `idx_o` and no bits to `mask_o`.
- R6: With PIPE=1, every output reflects the input sampled at the previous rising clock edge. With PIPE=0, the outputs follow the input within the same cycle.
- R7: With PIPE=1, the outputs read 0 while `rst_n` is low (active-low, asynchronous), whatever the input is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional pipeline register |
| rst_n | input | 1 | Active-low asynchronous reset of the pipeline register |
| vec_i | input | WIDTH | Word to scan |
| any_o | output | 1 | At least one input bit is set |
| idx_o | output | IDXW | Position of the highest set bit |
| mask_o | output | WIDTH | One-hot marker of the highest set bit |

## Verification
Two results can share the same index value. An all-zero word falls back to index 0, and a word whose only set bit is bit 0 also reports index 0. The exhaustive sweeps over 6-bit and 8-bit words produce both cases back to back, and they are told apart through `any_o` and `mask_o`. In the pipelined versions, a new word is applied in the same cycle that the previous word's result is on the outputs. The bench checks each result against the word from one edge earlier before it drives the next word.

// File: rtl/lead_one_locator.sv
module lead_one_locator #(
  parameter int WIDTH = 64,
  parameter bit PIPE  = 1'b1,
  localparam int IDXW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] vec_i,
  output logic             any_o,
  output logic [IDXW-1:0]  idx_o,
  output logic [WIDTH-1:0] mask_o
);

  function automatic int levels_for(input int w);
    int l, s;
    l = 1;
    s = 4;
    while (s < w) begin
      s = s * 4;
      l = l + 1;
    end
    return l;
  endfunction

  localparam int LEVELS = levels_for(WIDTH);
  localparam int PW     = 1 << (2 * LEVELS);
  localparam int PAD    = PW - WIDTH;
  localparam int TIW    = 2 * LEVELS;

  // four-way priority core, two ranks of 2:1 selects
  function automatic logic [1:0] pick4(input logic [3:0] f);
    logic hi;
    hi = f[3] | f[2];
    return hi ? {1'b1, f[3]} : {1'b0, f[1]};
  endfunction

  logic [PW-1:0] padv;
  assign padv = PW'(vec_i) << PAD;

  for (genvar l = 0; l < LEVELS; l++) begin : lv
    localparam int N  = PW >> (2 * (l + 1));
    localparam int IW = 2 * (l + 1);

    logic [N-1:0]  fl;
    logic [IW-1:0] ix [N];
    logic [N-1:0]  of_fl;
    logic [IW-1:0] of_ix [N];

    for (genvar n = 0; n < N; n++) begin : nd
      logic [3:0] cf;
      logic [1:0] code;
      if (l == 0) begin : g_leaf
        assign cf    = padv[4*n +: 4];
        assign code  = pick4(cf);
        assign ix[n] = code;
      end else begin : g_inner
        assign cf    = lv[l-1].of_fl[4*n +: 4];
        assign code  = pick4(cf);
        assign ix[n] = {code, lv[l-1].of_ix[4*n + int'(code)]};
      end
      assign fl[n] = |cf;
    end

    if (l == 0 && PIPE) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          of_fl <= '0;
          for (int k = 0; k < N; k++) of_ix[k] <= '0;
        end else begin
          of_fl <= fl;
          for (int k = 0; k < N; k++) of_ix[k] <= ix[k];
        end
      end
    end else begin : g_pass
      assign of_fl = fl;
      assign of_ix = ix;
    end
  end

  logic [TIW-1:0] pidx, ridx;
  assign any_o  = lv[LEVELS-1].of_fl[0];
  assign pidx   = lv[LEVELS-1].of_ix[0];
  assign ridx   = pidx - TIW'(PAD);
  assign idx_o  = any_o ? ridx[IDXW-1:0] : '0;
  assign mask_o = any_o ? (WIDTH'(1) << idx_o) : '0;

endmodule

// File: rtl/lead_one_locator_chk.sv
module lead_one_locator_chk #(
  parameter int WIDTH = 64,
  parameter bit PIPE  = 1'b1,
  localparam int IDXW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] vec_i,
  input logic             any_o,
  input logic [IDXW-1:0]  idx_o,
  input logic [WIDTH-1:0] mask_o
);

  logic [WIDTH-1:0] vdly, vref;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vdly <= '0;
    else        vdly <= vec_i;
  end

  assign vref = PIPE ? vdly : vec_i;

  assert_any_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    any_o == (vref != '0));

  assert_highest_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> ((vref >> idx_o) == WIDTH'(1)));

  assert_mask_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> ($countones(mask_o) == 1 && (mask_o & vref) == mask_o));

  assert_zero_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !any_o |-> (idx_o == '0 && mask_o == '0));

  always @(negedge clk) begin
    if (PIPE && !rst_n)
      assert_reset_clear_R7: assert (!any_o && idx_o == '0 && mask_o == '0);
  end

endmodule

bind lead_one_locator lead_one_locator_chk #(.WIDTH(WIDTH), .PIPE(PIPE)) u_chk (
  .clk(clk), .rst_n(rst_n), .vec_i(vec_i),
  .any_o(any_o), .idx_o(idx_o), .mask_o(mask_o)
);

// File: tb/lead_one_locator_bench.sv
module lead_one_locator_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [7:0]  v8;
  logic [5:0]  v6;
  logic [63:0] v64;
  logic        any8, any6, any64;
  logic [2:0]  idx8, idx6;
  logic [5:0]  idx64;
  logic [7:0]  mask8;
  logic [5:0]  mask6;
  logic [63:0] mask64;

  lead_one_locator #(.WIDTH(8), .PIPE(1'b1)) u_lead_one_locator (
    .clk(clk), .rst_n(rst_n), .vec_i(v8), .any_o(any8), .idx_o(idx8), .mask_o(mask8));
  lead_one_locator #(.WIDTH(6), .PIPE(1'b0)) u_w6 (
    .clk(clk), .rst_n(rst_n), .vec_i(v6), .any_o(any6), .idx_o(idx6), .mask_o(mask6));
  lead_one_locator #(.WIDTH(64), .PIPE(1'b1)) u_w64 (
    .clk(clk), .rst_n(rst_n), .vec_i(v64), .any_o(any64), .idx_o(idx64), .mask_o(mask64));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int top_bit(input logic [63:0] v, input int w);
    for (int b = w - 1; b >= 0; b--) if (v[b]) return b;
    return -1;
  endfunction

  // compares all three outputs with a scan from the top bit
  task automatic judge(input string grp, input int w, input logic [63:0] v,
                       input logic a, input logic [63:0] ix, input logic [63:0] m);
    int t;
    logic [63:0] ei, em;
    t  = top_bit(v, w);
    ei = (t >= 0) ? 64'(t) : 64'd0;
    em = (t >= 0) ? (64'd1 << t) : 64'd0;
    if (t < 0) begin
      chk({grp, " R4 any"},  64'(a), 64'd0);
      chk({grp, " R4 idx"},  ix, 64'd0);
      chk({grp, " R4 mask"}, m, 64'd0);
    end else begin
      chk({grp, " R1 any"},  64'(a), 64'd1);
      chk({grp, " R2 idx"},  ix, ei);
      chk({grp, " R3 mask"}, m, em);
    end
  endtask

  logic [7:0]  p8;
  logic [63:0] p64;

  initial begin
    v8 = 8'hA5; v6 = 6'h00; v64 = 64'h8000_0000_0000_0001;
    repeat (3) @(negedge clk);
    // R7: pipelined outputs held at zero during reset
    chk("R7 any w8",   64'(any8), 64'd0);
    chk("R7 mask w8",  64'(mask8), 64'd0);
    chk("R7 idx w64",  64'(idx64), 64'd0);
    chk("R7 any w64",  64'(any64), 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < 640; i++) begin
      if (i > 0) begin
        // R6: pipelined result belongs to the word driven one edge earlier
        judge("R6 w8", 8, 64'(p8), any8, 64'(idx8), 64'(mask8));
        judge("R6 w64", 64, p64, any64, 64'(idx64), mask64);
      end
      v8 = 8'(i);
      v6 = 6'(i);
      if (i < 256)      v64 = 64'(i) << (i % 57);
      else if (i < 320) v64 = (64'd1 << (i - 256)) | (64'd1 << ((i - 256) / 2));
      else              v64 = {$urandom, $urandom} >> ($urandom % 64);
      p8 = v8;
      p64 = v64;
      #1;
      // R5: width 6 is padded internally, combinational path (R6)
      judge("R5 w6", 6, 64'(v6), any6, 64'(idx6), 64'(mask6));
      @(negedge clk);
    end
    judge("R6 w8", 8, 64'(p8), any8, 64'(idx8), 64'(mask8));
    judge("R6 w64", 64, p64, any64, 64'(idx64), mask64);

    // R2: bits below the leading one leave every output unchanged
    v64 = 64'h0000_0400_0000_0000;
    @(negedge clk);
    chk("R2 lone idx", 64'(idx64), 64'd42);
    v64 = 64'h0000_07FF_FFFF_FFFF;
    @(negedge clk);
    chk("R2 filled idx", 64'(idx64), 64'd42);
    chk("R2 filled mask", mask64, 64'h0000_0400_0000_0000);
    done = 1'b1;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
    end
    done = 1'b1;
  end

  initial begin
    wait (done);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule